// File: doc/BRIEF.md
# Encapsulating UDP/IP Header Checker

This block inspects the outer IPv4 and UDP headers that sit behind an Ethernet header carrying one VLAN tag, which an earlier stage has already validated. The header bytes arrive one per cycle, starting with the first byte of the IPv4 header. The first byte comes with a start flag, the frame length measured on the Ethernet side, and the index of the slice that owns the packet. Once the last byte of the UDP header has been taken in, the block gives a pass or drop verdict with a reason code. With the verdict it gives a record for the next stage: the IP source address, both UDP ports, the offset of the UDP payload from the start of the frame, and the payload length.

Each slice has a set of event counters, one for each reason code, including a counter for passed packets. A combinational read port returns any one of them. The block covers the common case without IP options: it skips over option bytes to find the UDP header but does not interpret them. It does not verify checksums.

Top module: `ipu_hdr_checker`

## Requirements
- R1: A header whose version nibble (upper half of the first byte) is not 4 is dropped with reason code 1.
- R2: A header-length nibble (lower half of the first byte, in 32-bit words) below 5 causes a drop with reason code 2. The UDP header is then assumed to start at byte 20.
- R3: An IP total length (bytes 2 and 3, big-endian) smaller than the declared header length in bytes causes a drop with reason code 3.
- R4: The IP length implied by the frame is the frame length minus 22 (18 bytes of Ethernet and tag, 4 bytes of CRC). For a frame of any length other than 64, the total length must equal this value; otherwise the packet is dropped with reason code 4. A frame shorter than 22 bytes always gets code 4.
- R5: A frame of exactly 64 bytes is treated as padded. Its total length may be less than or equal to the implied length, and only a larger value gives code 4.
- R6: A protocol byte (byte 9) other than 17 causes a drop with reason code 5.
- R7: A UDP length field (bytes 4 and 5 of the UDP header) that differs from the total length minus the header length in bytes causes a drop with reason code 6.
- R8: When several checks fail, the lowest nonzero code is reported. A passing packet reports code 0 with the pass flag set.
- R9: Each verdict adds one to exactly one counter: the counter for the packet's slice whose kind index equals the reason code (0 = passed). All other counters are unchanged. The read port returns the counter chosen by slice and kind.
- R10: The verdict appears for exactly one cycle, in the cycle after the byte that completes the UDP header (header bytes + 8). The record holds the source address from bytes 12 to 15, both ports, a payload offset of 26 + header bytes, and a payload length of the UDP length minus 8.
- R11: A start flag in the middle of a packet drops the partial header and starts over. Bytes that arrive after a header is complete and before the next start flag are ignored.
- R12: The next packet may start in the cycle right after the last byte of the previous one. Both packets get correct verdicts and counter updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_valid | input | 1 | A header byte is present |
| hb_sof | input | 1 | This byte is the first IPv4 header byte |
| hb_data | input | 8 | Header byte |
| frame_len | input | LEN_W | Ethernet frame length in bytes, sampled with the start flag |
| slice_in | input | SLICE_W | Slice index, sampled with the start flag |
| res_valid | output | 1 | Verdict strobe |
| res_pass | output | 1 | Packet passed all checks |
| res_reason | output | 3 | Reason code (0 means passed) |
| res_slice | output | SLICE_W | Slice of the reported packet |
| res_src_addr | output | 32 | IP source address |
| res_sport | output | 16 | UDP source port |
| res_dport | output | 16 | UDP destination port |
| res_pay_off | output | LEN_W | Offset of the UDP payload from the start of the frame |
| res_pay_len | output | LEN_W | UDP payload length |
| cnt_rd_slice | input | SLICE_W | Slice selected for counter read |
| cnt_rd_kind | input | 3 | Counter kind selected (equals reason code) |
| cnt_rd_count | output | CNT_W | Selected counter value |

## Verification
Two things can happen in the same cycle. The verdict and counter update for one packet can land in the cycle that captures the start byte of the next packet. The bench provokes this by sending two packets back to back with no idle cycle, for different slices and with different outcomes. It then checks both verdicts, in order, and every counter of both slices against a model kept from the requirements. It also leaves the counter read port on a counter that changes at that edge, and checks that the value moves by one only after the edge.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

   typedef enum logic [2:0] {
      IPU_PASS         = 3'd0,
      IPU_BAD_VER      = 3'd1,
      IPU_BAD_IHL      = 3'd2,
      IPU_SHORT        = 3'd3,
      IPU_LEN_MISMATCH = 3'd4,
      IPU_BAD_PROTO    = 3'd5,
      IPU_UDP_MISMATCH = 3'd6
   } ipu_reason_e;

   localparam int          IPU_KINDS      = 7;
   localparam int          IPU_KIND_W     = 3;
   localparam logic [3:0]  IPU_IP_VER     = 4'd4;
   localparam logic [3:0]  IPU_MIN_IHL    = 4'd5;
   localparam logic [7:0]  IPU_UDP_PROTO  = 8'd17;
   localparam int          IPU_L2_BYTES   = 18;
   localparam int          IPU_CRC_BYTES  = 4;
   localparam int          IPU_UDP_BYTES  = 8;
   localparam int          IPU_PAD_FRAME  = 64;
   localparam int          IPU_MIN_HDR_B  = 20;

endpackage

// File: rtl/ipu_hdr_capture.sv
module ipu_hdr_capture
   import ipu_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hb_valid,
   input  logic               hb_sof,
   input  logic [7:0]         hb_data,
   input  logic [LEN_W-1:0]   frame_len,
   input  logic [SLICE_W-1:0] slice_in,
   output logic               cap_done,
   output logic [3:0]         cap_ver,
   output logic [3:0]         cap_ihl,
   output logic [15:0]        cap_tot,
   output logic [7:0]         cap_proto,
   output logic [31:0]        cap_src,
   output logic [15:0]        cap_sport,
   output logic [15:0]        cap_dport,
   output logic [15:0]        cap_ulen,
   output logic [LEN_W-1:0]   cap_flen,
   output logic [SLICE_W-1:0] cap_slice
);

   localparam int IDX_W = 7;

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] hdr_bytes;
   logic [IDX_W-1:0] last_idx;
   logic [IDX_W-1:0] rel;
   logic             in_udp;

   // Header bytes as declared; a bad length nibble falls back to the minimum.
   assign hdr_bytes = (cap_ihl < IPU_MIN_IHL) ? IDX_W'(IPU_MIN_HDR_B)
                                              : {1'b0, cap_ihl, 2'b00};
   assign last_idx  = hdr_bytes + IDX_W'(IPU_UDP_BYTES - 1);
   assign in_udp    = (idx >= hdr_bytes);
   assign rel       = idx - hdr_bytes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         cap_done  <= 1'b0;
         cap_ver   <= '0;
         cap_ihl   <= '0;
         cap_tot   <= '0;
         cap_proto <= '0;
         cap_src   <= '0;
         cap_sport <= '0;
         cap_dport <= '0;
         cap_ulen  <= '0;
         cap_flen  <= '0;
         cap_slice <= '0;
      end else begin
         cap_done <= 1'b0;
         if (hb_valid && hb_sof) begin
            busy      <= 1'b1;
            idx       <= IDX_W'(1);
            cap_ver   <= hb_data[7:4];
            cap_ihl   <= hb_data[3:0];
            cap_flen  <= frame_len;
            cap_slice <= slice_in;
         end else if (hb_valid && busy) begin
            case (idx)
               IDX_W'(2):  cap_tot[15:8]  <= hb_data;
               IDX_W'(3):  cap_tot[7:0]   <= hb_data;
               IDX_W'(9):  cap_proto      <= hb_data;
               IDX_W'(12): cap_src[31:24] <= hb_data;
               IDX_W'(13): cap_src[23:16] <= hb_data;
               IDX_W'(14): cap_src[15:8]  <= hb_data;
               IDX_W'(15): cap_src[7:0]   <= hb_data;
               default: ;
            endcase
            if (in_udp) begin
               case (rel)
                  IDX_W'(0): cap_sport[15:8] <= hb_data;
                  IDX_W'(1): cap_sport[7:0]  <= hb_data;
                  IDX_W'(2): cap_dport[15:8] <= hb_data;
                  IDX_W'(3): cap_dport[7:0]  <= hb_data;
                  IDX_W'(4): cap_ulen[15:8]  <= hb_data;
                  IDX_W'(5): cap_ulen[7:0]   <= hb_data;
                  default: ;
               endcase
            end
            if (idx == last_idx) begin
               busy     <= 1'b0;
               cap_done <= 1'b1;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end

   // R10: a header needs at least 28 bytes, so completions never touch
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |=> !cap_done);

   // R11: a start byte only arms capture, it never completes a header
   a_r11_sof_never_done: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_valid && hb_sof) |=> !cap_done);

endmodule

// File: rtl/ipu_hdr_rules.sv
module ipu_hdr_rules
   import ipu_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [3:0]       ver,
   input  logic [3:0]       ihl,
   input  logic [15:0]      tot,
   input  logic [7:0]       proto,
   input  logic [15:0]      ulen,
   input  logic [LEN_W-1:0] flen,
   output ipu_reason_e      reason,
   output logic [LEN_W-1:0] pay_off,
   output logic [LEN_W-1:0] pay_len
);

   localparam int XW = LEN_W + 1;

   logic [XW-1:0] tot_x, ulen_x, flen_x, hdr_x, eff_x;
   logic [XW-1:0] implied_x, udp_exp_x, off_x;
   logic          frame_short, padded, len_bad;

   assign tot_x  = XW'(tot);
   assign ulen_x = XW'(ulen);
   assign flen_x = XW'(flen);
   assign hdr_x  = XW'({ihl, 2'b00});
   assign eff_x  = (ihl < IPU_MIN_IHL) ? XW'(IPU_MIN_HDR_B) : hdr_x;

   assign frame_short = flen_x < XW'(IPU_L2_BYTES + IPU_CRC_BYTES);
   assign implied_x   = flen_x - XW'(IPU_L2_BYTES + IPU_CRC_BYTES);
   assign padded      = (flen_x == XW'(IPU_PAD_FRAME));
   assign len_bad     = frame_short || (tot_x > implied_x)
                     || (!padded && (tot_x != implied_x));
   assign udp_exp_x   = tot_x - hdr_x;

   always_comb begin
      if (ver != IPU_IP_VER)            reason = IPU_BAD_VER;
      else if (ihl < IPU_MIN_IHL)       reason = IPU_BAD_IHL;
      else if (tot_x < hdr_x)           reason = IPU_SHORT;
      else if (len_bad)                 reason = IPU_LEN_MISMATCH;
      else if (proto != IPU_UDP_PROTO)  reason = IPU_BAD_PROTO;
      else if (ulen_x != udp_exp_x)     reason = IPU_UDP_MISMATCH;
      else                              reason = IPU_PASS;
   end

   assign off_x   = eff_x + XW'(IPU_L2_BYTES + IPU_UDP_BYTES);
   assign pay_off = off_x[LEN_W-1:0];
   assign pay_len = LEN_W'(ulen - 16'(IPU_UDP_BYTES));

endmodule

// File: rtl/ipu_slice_counters.sv
module ipu_slice_counters
   import ipu_pkg::*;
#(
   parameter int NUM_SLICES = 16,
   parameter int SLICE_W    = 4,
   parameter int CNT_W      = 32,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc,
   input  logic [SLICE_W-1:0]    inc_slice,
   input  logic [IPU_KIND_W-1:0] inc_kind,
   input  logic [SLICE_W-1:0]    rd_slice,
   input  logic [IPU_KIND_W-1:0] rd_kind,
   output logic [CNT_W-1:0]      rd_count
);

   localparam int TOTAL = NUM_SLICES * IPU_KINDS;

   logic [CNT_W-1:0] cnt_flat [TOTAL];

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      for (genvar k = 0; k < IPU_KINDS; k++) begin : g_kind
         logic [CNT_W-1:0] cnt_q;
         logic             hit;
         assign hit = inc && (int'(inc_slice) == s) && (int'(inc_kind) == k);
         if (SATURATE) begin : g_sat
            always_ff @(posedge clk) begin
               if (!rst_n)                      cnt_q <= '0;
               else if (hit && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
            end
         end else begin : g_wrap
            always_ff @(posedge clk) begin
               if (!rst_n)   cnt_q <= '0;
               else if (hit) cnt_q <= cnt_q + 1'b1;
            end
         end
         assign cnt_flat[s*IPU_KINDS + k] = cnt_q;
      end
   end

   always_comb begin
      rd_count = '0;
      if ((int'(rd_slice) < NUM_SLICES) && (int'(rd_kind) < IPU_KINDS))
         rd_count = cnt_flat[int'(rd_slice)*IPU_KINDS + int'(rd_kind)];
   end

   // R9: with no verdict, a counter held on the read port does not move
   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> (!$stable(rd_slice) || !$stable(rd_kind) || $stable(rd_count)));

endmodule

// File: rtl/ipu_hdr_checker.sv
module ipu_hdr_checker
   import ipu_pkg::*;
#(
   parameter int NUM_SLICES   = 16,
   parameter int SLICE_W      = 4,
   parameter int CNT_W        = 32,
   parameter int LEN_W        = 16,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hb_valid,
   input  logic               hb_sof,
   input  logic [7:0]         hb_data,
   input  logic [LEN_W-1:0]   frame_len,
   input  logic [SLICE_W-1:0] slice_in,
   output logic               res_valid,
   output logic               res_pass,
   output logic [2:0]         res_reason,
   output logic [SLICE_W-1:0] res_slice,
   output logic [31:0]        res_src_addr,
   output logic [15:0]        res_sport,
   output logic [15:0]        res_dport,
   output logic [LEN_W-1:0]   res_pay_off,
   output logic [LEN_W-1:0]   res_pay_len,
   input  logic [SLICE_W-1:0] cnt_rd_slice,
   input  logic [2:0]         cnt_rd_kind,
   output logic [CNT_W-1:0]   cnt_rd_count
);

   if (NUM_SLICES < 1) begin : g_chk_slices
      $error("NUM_SLICES must be at least 1");
   end
   if ((2 ** SLICE_W) < NUM_SLICES) begin : g_chk_slice_w
      $error("SLICE_W too narrow for NUM_SLICES");
   end
   if (LEN_W < 16) begin : g_chk_len_w
      $error("LEN_W must hold a 16-bit IP length");
   end
   if (CNT_W < 1) begin : g_chk_cnt_w
      $error("CNT_W must be at least 1");
   end

   logic               cap_done;
   logic [3:0]         cap_ver, cap_ihl;
   logic [15:0]        cap_tot, cap_sport, cap_dport, cap_ulen;
   logic [7:0]         cap_proto;
   logic [31:0]        cap_src;
   logic [LEN_W-1:0]   cap_flen;
   logic [SLICE_W-1:0] cap_slice;
   ipu_reason_e        chk_reason;
   logic [LEN_W-1:0]   chk_off, chk_len;

   ipu_hdr_capture #(.LEN_W(LEN_W), .SLICE_W(SLICE_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .hb_valid  (hb_valid),
      .hb_sof    (hb_sof),
      .hb_data   (hb_data),
      .frame_len (frame_len),
      .slice_in  (slice_in),
      .cap_done  (cap_done),
      .cap_ver   (cap_ver),
      .cap_ihl   (cap_ihl),
      .cap_tot   (cap_tot),
      .cap_proto (cap_proto),
      .cap_src   (cap_src),
      .cap_sport (cap_sport),
      .cap_dport (cap_dport),
      .cap_ulen  (cap_ulen),
      .cap_flen  (cap_flen),
      .cap_slice (cap_slice)
   );

   ipu_hdr_rules #(.LEN_W(LEN_W)) u_rules (
      .ver     (cap_ver),
      .ihl     (cap_ihl),
      .tot     (cap_tot),
      .proto   (cap_proto),
      .ulen    (cap_ulen),
      .flen    (cap_flen),
      .reason  (chk_reason),
      .pay_off (chk_off),
      .pay_len (chk_len)
   );

   ipu_slice_counters #(
      .NUM_SLICES (NUM_SLICES),
      .SLICE_W    (SLICE_W),
      .CNT_W      (CNT_W),
      .SATURATE   (CNT_SATURATE)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (cap_done),
      .inc_slice (cap_slice),
      .inc_kind  (chk_reason),
      .rd_slice  (cnt_rd_slice),
      .rd_kind   (cnt_rd_kind),
      .rd_count  (cnt_rd_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_pass     <= 1'b0;
         res_reason   <= '0;
         res_slice    <= '0;
         res_src_addr <= '0;
         res_sport    <= '0;
         res_dport    <= '0;
         res_pay_off  <= '0;
         res_pay_len  <= '0;
      end else begin
         res_valid <= cap_done;
         if (cap_done) begin
            res_pass     <= (chk_reason == IPU_PASS);
            res_reason   <= chk_reason;
            res_slice    <= cap_slice;
            res_src_addr <= cap_src;
            res_sport    <= cap_sport;
            res_dport    <= cap_dport;
            res_pay_off  <= chk_off;
            res_pay_len  <= chk_len;
         end
      end
   end

   // R10: every verdict is preceded by a completed header capture
   a_r10_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(cap_done));

   // R10: a passing packet's payload starts no earlier than byte 46
   a_r10_min_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_pass) |-> (res_pay_off >= LEN_W'(46)));

   // R8: the pass flag and a zero code always agree
   a_r8_pass_code: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_pass == (res_reason == 3'd0)));

endmodule

// File: tb/tb_ipu_hdr_checker.sv
module tb_ipu_hdr_checker;

   localparam int NS = 16;
   localparam int SW = 4;
   localparam int CW = 32;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hb_valid = 1'b0, hb_sof = 1'b0;
   logic [7:0]    hb_data = '0;
   logic [LW-1:0] frame_len = '0;
   logic [SW-1:0] slice_in = '0;
   logic          res_valid, res_pass;
   logic [2:0]    res_reason;
   logic [SW-1:0] res_slice;
   logic [31:0]   res_src_addr;
   logic [15:0]   res_sport, res_dport;
   logic [LW-1:0] res_pay_off, res_pay_len;
   logic [SW-1:0] cnt_rd_slice = '0;
   logic [2:0]    cnt_rd_kind = '0;
   logic [CW-1:0] cnt_rd_count;

   ipu_hdr_checker #(.NUM_SLICES(NS), .SLICE_W(SW), .CNT_W(CW), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .hb_valid(hb_valid), .hb_sof(hb_sof),
      .hb_data(hb_data), .frame_len(frame_len), .slice_in(slice_in),
      .res_valid(res_valid), .res_pass(res_pass), .res_reason(res_reason),
      .res_slice(res_slice), .res_src_addr(res_src_addr), .res_sport(res_sport),
      .res_dport(res_dport), .res_pay_off(res_pay_off), .res_pay_len(res_pay_len),
      .cnt_rd_slice(cnt_rd_slice), .cnt_rd_kind(cnt_rd_kind),
      .cnt_rd_count(cnt_rd_count)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_cnt [NS][7];

   // Verdict log, filled away from the active edge
   int          n_res = 0;
   logic        r_pass   [32];
   logic [2:0]  r_reason [32];
   logic [SW-1:0] r_slice [32];
   logic [31:0] r_src    [32];
   logic [15:0] r_sp     [32];
   logic [15:0] r_dp     [32];
   logic [LW-1:0] r_off  [32];
   logic [LW-1:0] r_len  [32];

   always @(negedge clk) begin
      if (res_valid && n_res < 32) begin
         r_pass[n_res]   = res_pass;
         r_reason[n_res] = res_reason;
         r_slice[n_res]  = res_slice;
         r_src[n_res]    = res_src_addr;
         r_sp[n_res]     = res_sport;
         r_dp[n_res]     = res_dport;
         r_off[n_res]    = res_pay_off;
         r_len[n_res]    = res_pay_len;
         n_res = n_res + 1;
      end
   end

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_slice_counters(string tag, int s);
      for (int k = 0; k < 7; k++) begin
         cnt_rd_slice = SW'(s);
         cnt_rd_kind  = 3'(k);
         #1;
         check($sformatf("%s R9 counter slice %0d kind %0d", tag, s, k),
               cnt_rd_count, exp_cnt[s][k]);
      end
   endtask

   logic [7:0] pkt [80];
   int         pkt_n;

   task automatic build(input int ver, ihl, tot, proto, input logic [31:0] src,
                        input int sp, dp, ulen);
      int eff;
      for (int i = 0; i < 80; i++) pkt[i] = 8'h00;
      eff = (ihl < 5) ? 20 : ihl * 4;
      pkt[0]  = {4'(ver), 4'(ihl)};
      pkt[2]  = 8'(tot >> 8);  pkt[3] = 8'(tot);
      pkt[8]  = 8'd64;
      pkt[9]  = 8'(proto);
      pkt[12] = src[31:24]; pkt[13] = src[23:16];
      pkt[14] = src[15:8];  pkt[15] = src[7:0];
      pkt[eff+0] = 8'(sp >> 8);   pkt[eff+1] = 8'(sp);
      pkt[eff+2] = 8'(dp >> 8);   pkt[eff+3] = 8'(dp);
      pkt[eff+4] = 8'(ulen >> 8); pkt[eff+5] = 8'(ulen);
      pkt_n = eff + 8;
   endtask

   task automatic drive(input int flen, input int slc, input bit idle_after);
      for (int i = 0; i < pkt_n; i++) begin
         @(negedge clk);
         hb_valid  = 1'b1;
         hb_sof    = (i == 0);
         hb_data   = pkt[i];
         frame_len = LW'(flen);
         slice_in  = SW'(slc);
      end
      if (idle_after) begin
         @(negedge clk);
         hb_valid = 1'b0;
         hb_sof   = 1'b0;
      end
   endtask

   // One packet, one verdict: checks code, record and that slice's counters
   task automatic run_case(string tag, input int ver, ihl, tot, proto, sp, dp,
                           ulen, flen, slc, exp_code, exp_off, exp_len);
      int n0 = n_res;
      build(ver, ihl, tot, proto, 32'hC0A8_0107, sp, dp, ulen);
      drive(flen, slc, 1'b1);
      @(negedge clk); #1;
      check({tag, " R10 verdict count"}, n_res, n0 + 1);
      if (n_res == n0 + 1) begin
         check({tag, " reason"}, r_reason[n0], exp_code);
         check({tag, " R8 pass flag"}, r_pass[n0], exp_code == 0);
         check({tag, " R9 slice"}, r_slice[n0], slc);
         if (exp_code == 0) begin
            check({tag, " R10 src"}, r_src[n0], 32'hC0A8_0107);
            check({tag, " R10 sport"}, r_sp[n0], sp);
            check({tag, " R10 dport"}, r_dp[n0], dp);
            check({tag, " R10 offset"}, r_off[n0], exp_off);
            check({tag, " R10 length"}, r_len[n0], exp_len);
         end
      end
      exp_cnt[slc][exp_code]++;
      check_slice_counters(tag, slc);
   endtask

   task automatic t_reset();
      check("reset res_valid", res_valid, 0);
      check_slice_counters("reset", 0);
   endtask

   task automatic t_valid();
      run_case("R5 padded short ip",  4, 5, 28, 17, 1000, 2000,  8,  64, 1, 0, 46, 0);
      run_case("R4 exact ip len",     4, 5, 78, 17, 53,   4789, 58, 100, 2, 0, 46, 50);
      run_case("R10 ihl6 offset",     4, 6, 40, 17, 7,    8,    16,  62, 3, 0, 50, 8);
   endtask

   task automatic t_drops();
      run_case("R1 version 6",        6, 5, 28, 17, 1, 2,  8,  64, 4, 1, 0, 0);
      run_case("R2 ihl 3",            4, 3, 28, 17, 1, 2,  8,  64, 4, 2, 0, 0);
      run_case("R3 total below hdr",  4, 6, 22, 17, 1, 2,  8,  44, 4, 3, 0, 0);
      run_case("R4 unpadded short",   4, 5, 70, 17, 1, 2, 50, 100, 5, 4, 0, 0);
      run_case("R5 padded too long",  4, 5, 46, 17, 1, 2, 26,  64, 5, 4, 0, 0);
      run_case("R4 tiny frame",       4, 5, 28, 17, 1, 2,  8,  20, 5, 4, 0, 0);
      run_case("R6 protocol tcp",     4, 5, 28,  6, 1, 2,  8,  64, 6, 5, 0, 0);
      run_case("R7 udp len off",      4, 5, 78, 17, 1, 2, 50, 100, 6, 6, 0, 0);
   endtask

   task automatic t_priority();
      run_case("R8 ver+ihl",          6, 3, 10,  6, 1, 2, 99,  64, 7, 1, 0, 0);
      run_case("R8 ihl+len",          4, 4, 10, 17, 1, 2, 99,  64, 7, 2, 0, 0);
      run_case("R8 len+proto",        4, 5, 90,  6, 1, 2, 99, 100, 7, 4, 0, 0);
      run_case("R8 proto+udp",        4, 5, 28,  6, 1, 2, 99,  64, 7, 5, 0, 0);
   endtask

   task automatic t_restart_and_stray();
      int n0 = n_res;
      build(4, 5, 28, 17, 32'h0A00_0001, 9, 9, 8);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         hb_valid = 1'b1; hb_sof = (i == 0); hb_data = pkt[i];
         frame_len = LW'(64); slice_in = SW'(8);
      end
      run_case("R11 restart", 6, 5, 28, 17, 1, 2, 8, 64, 9, 1, 0, 0);
      check("R11 abandoned header gives no verdict", n_res, n0 + 1);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         hb_valid = 1'b1; hb_sof = 1'b0; hb_data = 8'h45;
      end
      @(negedge clk); hb_valid = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check("R11 stray bytes give no verdict", n_res, n0 + 1);
      check_slice_counters("R11 stray", 9);
      check_slice_counters("R11 stray", 8);
   endtask

   task automatic t_back_to_back();
      int n0 = n_res;
      cnt_rd_slice = SW'(10);
      cnt_rd_kind  = 3'd0;
      build(4, 5, 28, 17, 32'h0B0B_0B0B, 11, 12, 8);
      drive(64, 10, 1'b0);
      build(4, 5, 28, 6, 32'h0C0C_0C0C, 13, 14, 8);
      for (int i = 0; i < pkt_n; i++) begin
         @(negedge clk);
         hb_valid = 1'b1; hb_sof = (i == 0); hb_data = pkt[i];
         frame_len = LW'(64); slice_in = SW'(11);
         if (i == 0) check("R12 counter before edge", cnt_rd_count, exp_cnt[10][0]);
         if (i == 1) check("R12 counter after edge", cnt_rd_count, exp_cnt[10][0] + 1);
      end
      @(negedge clk); hb_valid = 1'b0; hb_sof = 1'b0;
      @(negedge clk); #1;
      check("R12 two verdicts", n_res, n0 + 2);
      if (n_res == n0 + 2) begin
         check("R12 first pass",    r_reason[n0], 0);
         check("R12 first slice",   r_slice[n0], 10);
         check("R12 first sport",   r_sp[n0], 11);
         check("R12 second code",   r_reason[n0+1], 5);
         check("R12 second slice",  r_slice[n0+1], 11);
      end
      exp_cnt[10][0]++;
      exp_cnt[11][5]++;
      check_slice_counters("R12", 10);
      check_slice_counters("R12", 11);
   endtask

   initial begin
      for (int s = 0; s < NS; s++)
         for (int k = 0; k < 7; k++) exp_cnt[s][k] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_valid();
      t_drops();
      t_priority();
      t_restart_and_stray();
      t_back_to_back();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule